// File: doc/BRIEF.md
# Fractional Divide and Detector Weight Controller

This block runs once per reference clock in a fractional-N synthesizer whose phase detector has two paths. One path compares the reference edge with the divider edge as it arrives. The other path compares it with the divider edge delayed by one oscillator period. On every reference edge the block adds a fractional control word to a modular accumulator. The overflow bit picks whether the divider counts N or N+1 in that cycle. The value left in the accumulator, called the residue, becomes the weight code for the delayed path. Full scale minus the residue becomes the weight code for the prompt path. Scaling the two detector errors this way keeps each error pulse at a constant area, which removes the fractional spurs.

The default weighting resolution is 7 bits, which gives a step of 1/128 of an oscillator period. Both weight codes are one bit wider than the fractional word so that the full-scale value of 128 can be encoded. An integer-only mode clears the accumulator. In that mode the block produces a steady divide of N, and all of the weight goes to the prompt path. The divide value and both weight codes leave the block from a single register stage, so all three describe the same reference cycle.

Top module: `fracn_divctl`

## Requirements
- R1: On a clock edge with `rst` high, the block loads `div_val` = N (the current `n_int`), `wt_late` = 0 and `wt_early` = 2^FRAC_W (128 at the defaults), and it clears the accumulator.
- R2: On each clock edge outside reset and outside integer mode, the accumulator takes the value (previous residue + `frac_word`) mod 2^FRAC_W, and `wt_late` carries that new residue in its low FRAC_W bits, with its top bit 0.
- R3: `div_val` is `n_int` + 1 on a cycle where that addition overflows (the sum reaches 2^FRAC_W or more), and `n_int` otherwise.
- R4: `wt_early` always equals 2^FRAC_W − `wt_late`, so the two codes sum to full scale. `wt_early` reaches 2^FRAC_W exactly when the residue is zero.
- R5: On an edge with `int_only` high, the block clears the accumulator and outputs `div_val` = N, `wt_late` = 0 and `wt_early` = full scale. Once `int_only` is released, accumulation starts again from a residue of zero.
- R6: A `frac_word` of zero applied from a zero residue keeps the residue at zero and the divide at N on every cycle.
- R7: All three outputs are registered on the same edge and reflect the inputs present at that edge, with a latency of one cycle.
- R8: `div_val` is INT_W+1 bits wide, so N = 2^INT_W−1 with a carry yields 2^INT_W without wrapping. A new `n_int` takes effect at the next edge.
- R9: A `frac_word` of 2^FRAC_W−1 produces a carry on every cycle except those where the residue is zero before the addition, and the residue steps down by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one update per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| int_only | input | 1 | Integer-only mode: clears the accumulator, divide N |
| n_int | input | INT_W | Integer divide value N |
| frac_word | input | FRAC_W | Fractional control word added every cycle |
| div_val | output | INT_W+1 | Divide value for this cycle (N or N+1) |
| wt_late | output | FRAC_W+1 | Weight code for the delayed-edge detector path (residue) |
| wt_early | output | FRAC_W+1 | Weight code for the prompt detector path (full scale minus residue) |

## Verification
On every cycle the assertions check four things: the two weight codes sum to full scale, the divide stays within {N, N+1} of the previous input, the reset and integer-mode output values are correct, and the new residue together with the carry equals the old residue plus the fractional word. Other properties appear only in the bench's scenarios. These are the length of the carry pattern for a given word (one in four cycles for a word of 32, nearly every cycle for 127), the restart from zero after integer mode, the held zero residue for a zero word, and the divide reaching 256 when N is at its maximum.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int FRAC_W_DEF = 7;
    localparam int INT_W_DEF  = 8;

    typedef enum logic {
        MODE_FRAC = 1'b0,
        MODE_INT  = 1'b1
    } fracn_mode_t;

    function automatic fracn_mode_t mode_of(input logic int_only);
        return int_only ? MODE_INT : MODE_FRAC;
    endfunction

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
    parameter int FRAC_W = fracn_pkg::FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [FRAC_W-1:0] step,
    output logic              carry,
    output logic [FRAC_W-1:0] residue
);
    localparam int SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] acc_q;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        if (clear) begin
            sum = '0;
        end else begin
            sum = {1'b0, acc_q} + {1'b0, step};
        end
    end

    assign carry   = sum[FRAC_W];
    assign residue = sum[FRAC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= residue;
        end
    end
endmodule

// File: rtl/fracn_weight.sv
module fracn_weight #(
    parameter int FRAC_W = fracn_pkg::FRAC_W_DEF
) (
    input  logic [FRAC_W-1:0] residue,
    output logic [FRAC_W:0]   late_code,
    output logic [FRAC_W:0]   early_code
);
    localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    always_comb begin
        late_code  = {1'b0, residue};
        early_code = FULL - late_code;
    end
endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
    parameter int FRAC_W = fracn_pkg::FRAC_W_DEF,
    parameter int INT_W  = fracn_pkg::INT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              int_only,
    input  logic [INT_W-1:0]  n_int,
    input  logic [FRAC_W-1:0] frac_word,
    output logic [INT_W:0]    div_val,
    output logic [FRAC_W:0]   wt_late,
    output logic [FRAC_W:0]   wt_early
);
    import fracn_pkg::*;

    localparam int DIV_W = INT_W + 1;
    localparam int WT_W  = FRAC_W + 1;
    localparam logic [WT_W-1:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [WT_W-1:0]  late;
        logic [WT_W-1:0]  early;
    } ctrl_word_t;

    fracn_mode_t       mode;
    logic              ovf;
    logic [FRAC_W-1:0] res;
    ctrl_word_t        nxt;
    ctrl_word_t        cur_q;
    logic [WT_W-1:0]   late_c;
    logic [WT_W-1:0]   early_c;

    assign mode = mode_of(int_only);

    fracn_accum #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (mode == MODE_INT),
        .step    (frac_word),
        .carry   (ovf),
        .residue (res)
    );

    fracn_weight #(.FRAC_W(FRAC_W)) u_wt (
        .residue    (res),
        .late_code  (late_c),
        .early_code (early_c)
    );

    always_comb begin
        nxt.div   = {1'b0, n_int} + DIV_W'(ovf);
        nxt.late  = late_c;
        nxt.early = early_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.div   <= {1'b0, n_int};
            cur_q.late  <= '0;
            cur_q.early <= FULL;
        end else begin
            cur_q <= nxt;
        end
    end

    assign div_val  = cur_q.div;
    assign wt_late  = cur_q.late;
    assign wt_early = cur_q.early;
endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
    parameter int FRAC_W = fracn_pkg::FRAC_W_DEF,
    parameter int INT_W  = fracn_pkg::INT_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              int_only,
    input logic [INT_W-1:0]  n_int,
    input logic [FRAC_W-1:0] frac_word,
    input logic [INT_W:0]    div_val,
    input logic [FRAC_W:0]   wt_late,
    input logic [FRAC_W:0]   wt_early
);
    localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};

    // R4: the two weights always sum to full scale
    a_r4_weights_sum: assert property (@(posedge clk) disable iff (rst)
        (wt_late + wt_early) == FULL);

    // R3 / R8: the divide is N or N+1 of the previous cycle's N
    a_r3_div_range: assert property (@(posedge clk) disable iff (rst)
        (div_val == {1'b0, $past(n_int)}) ||
        (div_val == ({1'b0, $past(n_int)} + 1'b1)));

    // R1: the first cycle after reset shows the reset values
    a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wt_late == '0) && (div_val == {1'b0, $past(n_int)}));

    // R5: integer mode gives divide N and zero residue
    a_r5_int_mode: assert property (@(posedge clk) disable iff (rst)
        $past(int_only) |-> (wt_late == '0) && (div_val == {1'b0, $past(n_int)}));

    // R2 / R3: new residue and carry equal old residue plus the word
    a_r2_accumulate: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!int_only)) |->
        (({1'b0, $past(wt_late[FRAC_W-1:0])} + {1'b0, $past(frac_word)}) ==
         {(div_val != {1'b0, $past(n_int)}), wt_late[FRAC_W-1:0]}));

    // R2: the top bit of the delayed-path code is never set
    a_r2_late_msb: assert property (@(posedge clk) disable iff (rst)
        wt_late[FRAC_W] == 1'b0);
endmodule

bind fracn_divctl fracn_divctl_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .int_only  (int_only),
    .n_int     (n_int),
    .frac_word (frac_word),
    .div_val   (div_val),
    .wt_late   (wt_late),
    .wt_early  (wt_early)
);

// File: tb/sim_fracn_divctl.sv
module sim_fracn_divctl;
    localparam int FW = 7;
    localparam int IW = 8;
    localparam int FULL = 1 << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          int_only = 1'b0;
    logic [IW-1:0] n_int = 8'd73;
    logic [FW-1:0] frac_word = '0;
    logic [IW:0]   div_val;
    logic [FW:0]   wt_late;
    logic [FW:0]   wt_early;

    always #4 clk = ~clk;

    fracn_divctl #(.FRAC_W(FW), .INT_W(IW)) u0 (
        .clk(clk), .rst(rst), .int_only(int_only), .n_int(n_int),
        .frac_word(frac_word), .div_val(div_val), .wt_late(wt_late),
        .wt_early(wt_early)
    );

    int    tests = 0;
    int    fails = 0;
    int    model_acc = 0;
    bit    done = 1'b0;
    int    exp_div_q[$];
    int    exp_late_q[$];
    string tag_q[$];

    // Driver: apply inputs on the falling edge and queue what the next rising edge must produce
    task automatic step(input bit r, input bit im, input int n, input int f, input string tag);
        int sum;
        int ed;
        @(negedge clk);
        rst = r;
        int_only = im;
        n_int = IW'(n);
        frac_word = FW'(f);
        if (r || im) begin
            model_acc = 0;
            ed = n;
        end else begin
            sum = model_acc + f;
            ed = n + (sum >= FULL ? 1 : 0);
            model_acc = sum % FULL;
        end
        exp_div_q.push_back(ed);
        exp_late_q.push_back(model_acc);
        tag_q.push_back(tag);
    endtask

    // Monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_div_q.size() > 0) begin
                int ed;
                int el;
                string t;
                ed = exp_div_q.pop_front();
                el = exp_late_q.pop_front();
                t = tag_q.pop_front();
                tests++;
                if (int'(div_val) != ed || int'(wt_late) != el || int'(wt_early) != FULL - el) begin
                    fails++;
                    $display("FAIL %s: div=%0d late=%0d early=%0d expected div=%0d late=%0d early=%0d",
                             t, div_val, wt_late, wt_early, ed, el, FULL - el);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: run did not finish, cycles=%0d expected<20000", cyc);
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset values, including with a nonzero word present
        step(1, 0, 73, 45, "R1");
        step(1, 0, 73, 45, "R1");
        // R2 R3 R4 R7: word 32, carry every fourth cycle
        for (int i = 0; i < 10; i++) step(0, 0, 73, 32, "R2_R3_R4_R7");
        // R5: integer mode clears mid-sequence
        step(0, 0, 73, 100, "R2");
        step(0, 1, 73, 100, "R5");
        step(0, 1, 73, 100, "R5");
        // R5: restart from zero after release
        for (int i = 0; i < 3; i++) step(0, 0, 73, 100, "R5_restart");
        // R6: zero word from a zero residue holds zero
        step(0, 1, 73, 0, "R5");
        for (int i = 0; i < 5; i++) step(0, 0, 73, 0, "R6");
        // R9: maximal word
        for (int i = 0; i < 6; i++) step(0, 0, 73, 127, "R9");
        // R8: maximum N with a carry reaches 256; N changes take effect next edge
        step(1, 0, 255, 0, "R1");
        for (int i = 0; i < 4; i++) step(0, 0, 255, 64, "R8");
        step(0, 0, 10, 64, "R8");
        step(0, 0, 200, 64, "R8");
        // R2 R4: word 1 and an odd word
        for (int i = 0; i < 4; i++) step(0, 0, 73, 1, "R2_R4");
        for (int i = 0; i < 8; i++) step(0, 0, 73, 77, "R3_R4");
        // R1: reset again clears a nonzero residue
        step(1, 0, 50, 77, "R1");
        step(0, 0, 50, 3, "R1_after");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule